// File: doc/BRIEF.md
# Serial Block-Write Configuration Slave

This block is a two-wire serial slave that holds a bank of 8-bit configuration registers. SCL and SDA are oversampled on the system clock. Start and stop conditions are recognised from SDA edges while SCL is high. The slave answers one 7-bit address, 69h, which appears on the wire as the byte D2h for a write and D3h for a read. It takes part in only two kinds of transaction: a block write that loads the bank from register 0 upward, and a block read that returns a length byte and then the bank from register 0 upward.

In a write, the two bytes after the address are acknowledged and discarded. Every later byte goes to the next register in order, until the master issues a stop. One register, the length register at index 8, sets how many bytes a read returns, and it can never be zero. Two register pairs are loaded together or not at all. A byte written to either member of a pair waits in a staging register. Both members of the pair are updated at the stop, and only if the same transaction delivered both of their bytes.

Inside the block, the byte engine hands each received data byte to the register bank through a valid/ready pair. The bank replies in the same cycle. `ready` high means the byte is taken and acknowledged. `ready` low refuses the byte: the engine answers NACK and ignores the rest of the transaction. There is no other back-pressure, and the block never stretches SCL. The block drives SDA only through `sda_pull`, an open-drain pull-down.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, every register reads 00h except the length register (index 8), which reads 08h, and `sda_pull` is low.
- R2: Only the address bytes D2h (write) and D3h (read) are acknowledged. Any other address gets no acknowledge, and the registers do not change for the rest of that transaction.
- R3: In a write, the first two bytes after the address are acknowledged, and their values are stored nowhere.
- R4: In a write, the third and later bytes load registers 0, 1, 2, … in order, and each one is acknowledged. After a stop, the registers written so far keep their new values and the rest keep their old values.
- R5: A data byte aimed past the last register (index 16 and above with 16 registers) is not acknowledged, and no register changes.
- R6: A 00h aimed at the length register is not acknowledged. The length register keeps its old value, and the rest of the transaction is ignored.
- R7: Registers 11/12 form one pair and registers 13/14 another. Their visible values change only at a stop, and only when both members of the pair were written in that transaction. Otherwise neither member changes.
- R8: In a read, the slave first sends the length register value, then registers 0, 1, 2, … MSB first. It stops driving after the master answers a byte with NACK.
- R9: In a read, once N register bytes have been sent (N being the length register value), every further byte the master acknowledges reads FFh, because the slave leaves SDA released.
- R10: `sda_pull` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset that loads the register defaults |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | High means drive SDA low (open-drain pull-down) |
| cfg_regs | output | NUM_REGS*8 | Register bank contents, register i at bits [8i+7:8i] |

## Verification
The bench goes after the places where the byte position decides what happens. If the command or count byte lands in register 0, the whole bank is shifted by one or two places. A 00h sent to the length register must be refused; a design that took it would return an empty read and leave its own length register at zero. A write that reaches only one member of a register pair must leave both members alone, and the pair must not show up early, before the stop. A design that loaded pair members directly would show half-written pairs. Reads that ask for more bytes than the length register allows must return FFh, not stale or wrapped register data.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W + 1);
  localparam int POS_W  = BYTE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } eng_state_t;
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[LAST];
      sda_d    <= sda_pipe[LAST];
    end
  end

  assign scl_s    = scl_pipe[LAST];
  assign sda_s    = sda_pipe[LAST];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfg_byte_engine.sv
module cfg_byte_engine
  import cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  output logic              sda_pull,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic [POS_W-1:0]  rx_idx,
  output logic [POS_W-1:0]  tx_pos,
  input  logic [BYTE_W-1:0] tx_data
);
  localparam logic [BIT_W-1:0] FULL = BIT_W'(BYTE_W);
  localparam logic [POS_W-1:0] HDR  = POS_W'(2);

  eng_state_t        st;
  logic [BYTE_W-1:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic [POS_W-1:0]  pos;
  logic              rw;
  logic              more;
  logic              byte_done;
  logic              pos_max;

  assign byte_done = (bitcnt == FULL);
  assign pos_max   = &pos;
  assign rx_valid  = (st == ST_WRX) && scl_fall && byte_done && (pos >= HDR);
  assign rx_data   = shreg;
  assign rx_idx    = pos - HDR;
  assign tx_pos    = pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      pos      <= '0;
      rw       <= 1'b0;
      more     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_p) begin
      st       <= ST_ADDR;
      bitcnt   <= '0;
      pos      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_p) begin
      st       <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WRX: begin
          if (scl_rise && !byte_done) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && byte_done) begin
            bitcnt <= '0;
            if (st == ST_ADDR) begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                rw       <= shreg[0];
                sda_pull <= 1'b1;
                st       <= ST_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if ((pos < HDR) || rx_ready) begin
              sda_pull <= 1'b1;
              st       <= ST_ACK;
              if (!pos_max) pos <= pos + 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              shreg    <= tx_data;
              sda_pull <= ~tx_data[BYTE_W-1];
              bitcnt   <= BIT_W'(1);
              st       <= ST_TX;
            end else begin
              sda_pull <= 1'b0;
              st       <= ST_WRX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (byte_done) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              st       <= ST_TXACK;
              if (!pos_max) pos <= pos + 1'b1;
            end else begin
              sda_pull <= ~shreg[BYTE_W-2];
              shreg    <= {shreg[BYTE_W-2:0], 1'b0};
              bitcnt   <= bitcnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            more <= ~sda_s;
          end else if (scl_fall) begin
            if (more) begin
              shreg    <= tx_data;
              sda_pull <= ~tx_data[BYTE_W-1];
              bitcnt   <= BIT_W'(1);
              st       <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int              NUM_REGS    = 16,
  parameter int              LEN_IDX     = 8,
  parameter logic [BYTE_W-1:0] LEN_DEFAULT = 8'h08,
  parameter int              PAIR_BASE   = 11,
  parameter int              NUM_PAIRS   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_p,
  input  logic                       stop_p,
  input  logic                       rx_valid,
  output logic                       rx_ready,
  input  logic [BYTE_W-1:0]          rx_data,
  input  logic [POS_W-1:0]           rx_idx,
  input  logic [POS_W-1:0]           tx_pos,
  output logic [BYTE_W-1:0]          tx_data,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
  localparam int PAIR_END = PAIR_BASE + 2 * NUM_PAIRS;

  logic [NUM_REGS-1:0]  got_vec;
  logic [NUM_PAIRS-1:0] pair_full;
  logic [BYTE_W-1:0]    len_q;

  assign len_q    = cfg_regs[LEN_IDX*BYTE_W +: BYTE_W];
  assign rx_ready = (rx_idx < POS_W'(NUM_REGS)) &&
                    !((rx_idx == POS_W'(LEN_IDX)) && (rx_data == '0));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_full[p] = got_vec[PAIR_BASE + 2*p] & got_vec[PAIR_BASE + 2*p + 1];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam bit IN_PAIR = (i >= PAIR_BASE) && (i < PAIR_END);
    localparam logic [BYTE_W-1:0] RST = (i == LEN_IDX) ? LEN_DEFAULT : '0;
    logic              hit;
    logic [BYTE_W-1:0] val_q;

    assign hit = rx_valid && rx_ready && (rx_idx == POS_W'(i));

    if (IN_PAIR) begin : g_paired
      localparam int PIDX = (i - PAIR_BASE) / 2;
      logic [BYTE_W-1:0] stage_q;
      logic              got_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q   <= RST;
          stage_q <= '0;
          got_q   <= 1'b0;
        end else if (start_p) begin
          got_q <= 1'b0;
        end else if (stop_p) begin
          if (pair_full[PIDX]) val_q <= stage_q;
          got_q <= 1'b0;
        end else if (hit) begin
          stage_q <= rx_data;
          got_q   <= 1'b1;
        end
      end
      assign got_vec[i] = got_q;
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= RST;
        else if (hit) val_q <= rx_data;
      end
      assign got_vec[i] = 1'b0;
    end

    assign cfg_regs[i*BYTE_W +: BYTE_W] = val_q;
  end

  always_comb begin
    tx_data = '1;
    if (tx_pos == '0) begin
      tx_data = len_q;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if ((tx_pos == POS_W'(i + 1)) && (POS_W'(i + 1) <= {1'b0, len_q}))
          tx_data = cfg_regs[i*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h69,
  parameter int                NUM_REGS    = 16,
  parameter int                LEN_IDX     = 8,
  parameter logic [BYTE_W-1:0] LEN_DEFAULT = 8'h08,
  parameter int                PAIR_BASE   = 11,
  parameter int                NUM_PAIRS   = 2,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_pull,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              rx_valid, rx_ready;
  logic [BYTE_W-1:0] rx_data, tx_data;
  logic [POS_W-1:0]  rx_idx, tx_pos;

  cfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  cfg_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .sda_pull(sda_pull), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_idx(rx_idx), .tx_pos(tx_pos), .tx_data(tx_data)
  );

  cfg_reg_bank #(
    .NUM_REGS(NUM_REGS), .LEN_IDX(LEN_IDX), .LEN_DEFAULT(LEN_DEFAULT),
    .PAIR_BASE(PAIR_BASE), .NUM_PAIRS(NUM_PAIRS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_idx(rx_idx), .tx_pos(tx_pos), .tx_data(tx_data), .cfg_regs(cfg_regs)
  );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
  import cfg_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int LEN_IDX   = 8,
  parameter int PAIR_BASE = 11,
  parameter int NUM_PAIRS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_s,
  input logic                       stop_p,
  input logic                       sda_pull,
  input logic [NUM_REGS*BYTE_W-1:0] cfg_regs,
  input logic                       rx_valid,
  input logic                       rx_ready,
  input logic [POS_W-1:0]           rx_idx,
  input logic [BYTE_W-1:0]          rx_data
);
  localparam int PLO = PAIR_BASE * BYTE_W;
  localparam int PHI = (PAIR_BASE + 2 * NUM_PAIRS) * BYTE_W - 1;

  function automatic logic plain_idx(input logic [POS_W-1:0] i);
    return (i < POS_W'(NUM_REGS)) &&
           !((i >= POS_W'(PAIR_BASE)) && (i < POS_W'(PAIR_BASE + 2 * NUM_PAIRS)));
  endfunction

  // R10
  pull_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  // R10
  pull_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_s);

  // R7
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_p |=> $stable(cfg_regs[PHI:PLO]));

  // R6
  len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (rx_idx == POS_W'(LEN_IDX)) && (rx_data == '0))
    |=> $stable(cfg_regs[LEN_IDX*BYTE_W +: BYTE_W]));

  // R5
  over_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (rx_idx >= POS_W'(NUM_REGS))) |=> $stable(cfg_regs));

  // R4
  seq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && plain_idx(rx_idx))
    |=> (cfg_regs[$past(rx_idx)*BYTE_W +: BYTE_W] == $past(rx_data)));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(
  .NUM_REGS(NUM_REGS), .LEN_IDX(LEN_IDX), .PAIR_BASE(PAIR_BASE), .NUM_PAIRS(NUM_PAIRS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_p(stop_p), .sda_pull(sda_pull),
  .cfg_regs(cfg_regs), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_idx(rx_idx), .rx_data(rx_data)
);

// File: tb/cfg_serial_slave_bench.sv
module cfg_serial_slave_bench;
  localparam int NREG = 16;
  localparam int LENI = 8;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_bus;
  logic [NREG*8-1:0] cfg_regs;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_regs [NREG];
  logic [7:0] wbuf [32];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  cfg_serial_slave u_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .cfg_regs(cfg_regs)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [127:0] pack_exp();
    logic [127:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_regs[i];
    return v;
  endfunction

  task automatic check_regs(input string tag);
    check(cfg_regs == pack_exp(), tag, cfg_regs, pack_exp());
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic bit_out(input bit b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit v;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(v);
    ack = !v;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      d[i] = v;
    end
    bit_out(!mack);
  endtask

  // Block write of n data bytes from wbuf, with expected results from the requirements
  task automatic do_write(input int n);
    bit ack;
    bit alive;
    bit got [NREG];
    logic [7:0] stg [NREG];
    for (int i = 0; i < NREG; i++) begin got[i] = 1'b0; stg[i] = '0; end
    alive = 1'b1;
    bus_start();
    send_byte(8'hD2, ack);
    check(ack, "R2 write address ack", ack, 1);
    send_byte(8'h5A, ack);
    check(ack, "R3 command byte ack", ack, 1);
    send_byte(8'hC3, ack);
    check(ack, "R3 count byte ack", ack, 1);
    for (int i = 0; i < n && alive; i++) begin
      bit ex;
      ex = (i < NREG) && !((i == LENI) && (wbuf[i] == 8'h00));
      send_byte(wbuf[i], ack);
      if (i >= NREG)
        check(ack == ex, "R5 byte past end refused", ack, ex);
      else if (i == LENI && wbuf[i] == 8'h00)
        check(ack == ex, "R6 zero length refused", ack, ex);
      else
        check(ack == ex, "R4 data byte ack", ack, ex);
      if (!ex) alive = 1'b0;
      else if (i >= 11 && i <= 14) begin stg[i] = wbuf[i]; got[i] = 1'b1; end
      else exp_regs[i] = wbuf[i];
    end
    check_regs("R7 pair registers unchanged before stop");
    bus_stop();
    for (int p = 11; p <= 13; p += 2)
      if (got[p] && got[p+1]) begin
        exp_regs[p] = stg[p];
        exp_regs[p+1] = stg[p+1];
      end
    qwait();
  endtask

  task automatic do_read(input int nb, input string tag);
    bit ack;
    logic [7:0] d;
    logic [7:0] ex;
    bus_start();
    send_byte(8'hD3, ack);
    check(ack, "R2 read address ack", ack, 1);
    recv_byte(nb > 0, d);
    check(d == exp_regs[LENI], "R8 length byte first", d, exp_regs[LENI]);
    for (int i = 0; i < nb; i++) begin
      recv_byte(i < nb - 1, d);
      ex = (i < int'(exp_regs[LENI]) && i < NREG) ? exp_regs[i] : 8'hFF;
      check(d == ex, tag, d, ex);
    end
    bus_stop();
    check(!sda_pull, "R8 released after master NACK", sda_pull, 0);
    qwait();
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) exp_regs[i] = (i == LENI) ? 8'h08 : 8'h00;
    check_regs("R1 reset values");
    check(!sda_pull, "R1 SDA released after reset", sda_pull, 0);
  endtask

  task automatic t_basic();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(3);
    check_regs("R3 R4 sequential write, header bytes dropped");
  endtask

  task automatic t_partial();
    wbuf[0] = 8'hA0;
    do_write(1);
    check_regs("R4 stop after first byte");
  endtask

  task automatic t_wrong_addr();
    bit ack;
    bus_start();
    send_byte(8'hA4, ack);
    check(!ack, "R2 foreign address not acked", ack, 0);
    send_byte(8'h00, ack);
    bus_stop();
    qwait();
    check_regs("R2 foreign address leaves registers");
  endtask

  task automatic t_len_zero();
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h40 + 8'(i);
    wbuf[8] = 8'h00;
    wbuf[9] = 8'h77;
    do_write(10);
    check(cfg_regs[LENI*8 +: 8] == 8'h08, "R6 length register kept", cfg_regs[LENI*8 +: 8], 8'h08);
    check_regs("R6 bank after refused zero");
  endtask

  task automatic t_pair_both();
    for (int i = 0; i < 14; i++) wbuf[i] = 8'h60 + 8'(i);
    wbuf[8] = 8'h03; wbuf[11] = 8'hAB; wbuf[12] = 8'hCD; wbuf[13] = 8'hEF;
    do_write(14);
    check(cfg_regs[11*8 +: 16] == 16'hCDAB, "R7 full pair committed", cfg_regs[11*8 +: 16], 16'hCDAB);
    check(cfg_regs[13*8 +: 8] == 8'h00, "R7 half pair not loaded", cfg_regs[13*8 +: 8], 8'h00);
  endtask

  task automatic t_pair_single();
    for (int i = 0; i < 12; i++) wbuf[i] = 8'h20 + 8'(i);
    wbuf[11] = 8'h99;
    do_write(12);
    check(cfg_regs[11*8 +: 8] == 8'hAB, "R7 single member ignored", cfg_regs[11*8 +: 8], 8'hAB);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 17; i++) wbuf[i] = 8'h80 + 8'(i);
    wbuf[8] = 8'h05; wbuf[13] = 8'h5E; wbuf[14] = 8'hE5;
    do_write(17);
    check_regs("R5 R7 bank after overlong write");
  endtask

  task automatic t_read();
    do_read(5, "R8 register data in order");
    do_read(7, "R9 bytes past length read FFh");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_wrong_addr();
    t_len_zero();
    t_pair_both();
    t_pair_single();
    t_overflow();
    t_read();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule